// File: doc/BRIEF.md
# Bit-level run-length encoder

This block compresses a serial bit stream by measuring runs of identical bits. It pulls 8-bit segments from an upstream FIFO, examines them one bit at a time starting from the least-significant bit, and writes one code word per run to a downstream FIFO. A code word carries the run's bit value in its top bit and the run length in the bits below. A run that reaches the end of a segment keeps growing into the next segment.

Both FIFO interfaces use single-cycle request pulses. Each pulse is followed by a one-cycle stall before the machine moves on. A request is only raised when the matching ready input (upstream not empty, downstream not full) was high. An end-of-stream input makes the machine flush the last partial run once the upstream FIFO has run dry. A run that hits the largest count the length field can hold is closed at that count, and a new run of the same value starts, so the count never wraps.

Top module: `bit_run_encoder`

## Requirements
- R1: A synchronous active-high reset holds `rd_req` and `wr_req` low, and no code word is written until input has been read.
- R2: `word_out` is CNT_W+1 bits wide (24 with the default CNT_W of 23). Bit CNT_W holds the run's bit value and bits CNT_W-1:0 hold its length, which is never zero in a written word.
- R3: Within each segment, bit 0 is examined first and bit SEG_W-1 last.
- R4: A run continues across segment boundaries. Two segments of all ones give a single word with value 1 and length 16.
- R5: `rd_req` is a one-cycle pulse, raised only when `src_ready` was high in the cycle before. Exactly one pulse is issued per segment consumed, and the segment is taken from `src_data` two clocks after the pulse rises.
- R6: `wr_req` is a one-cycle pulse, raised only when `sink_ready` was high in the cycle before. `word_out` holds the finished word while `wr_req` is high.
- R7: While `sink_ready` is low, a finished word waits and no word is lost or reordered.
- R8: When `src_ready` is low and `stream_end` is high with a nonzero pending length, the pending run is written as a final word. With zero pending length, nothing is written.
- R9: `stream_end` has no effect while `src_ready` is high: no run is flushed early.
- R10: A run reaching the maximum length 2^CNT_W-1 is written with that length, and counting continues as a new run of the same value.
- R11: `rd_req` and `wr_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ready | input | 1 | Upstream FIFO holds data |
| src_data | input | SEG_W (8) | Segment from upstream FIFO |
| stream_end | input | 1 | No more segments will arrive; flush pending run |
| sink_ready | input | 1 | Downstream FIFO has room |
| rd_req | output | 1 | Read request pulse to upstream FIFO |
| wr_req | output | 1 | Write request pulse to downstream FIFO |
| word_out | output | CNT_W+1 (24) | Code word: run value on top, run length below |

## Verification
The bound checker watches the handshake on every cycle: both request pulses last one cycle, each is raised only after its ready input was high, the two never overlap, reset leaves both low, and no written word carries a zero length. Only the bench scenarios can show what the words contain. They cover least-significant-first ordering, runs that span segments, the alternating worst case, saturation at the maximum length, the end-of-stream flush with and without a pending run, and word delivery under a stalled downstream FIFO.

// File: rtl/bit_run_encoder.sv
module bit_run_encoder #(
  parameter int SEG_W = 8,
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_ready,
  input  logic [SEG_W-1:0] src_data,
  input  logic             stream_end,
  input  logic             sink_ready,
  output logic             rd_req,
  output logic             wr_req,
  output logic [CNT_W:0]   word_out
);
  localparam int IDX_W = $clog2(SEG_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SEG_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [3:0] {
    ST_INIT, ST_FETCH, ST_IN_STALL, ST_LOAD, ST_COUNT,
    ST_SHIFT, ST_EMIT, ST_OUT_STALL, ST_CLEAR
  } state_t;

  state_t st, st_nx;
  logic [SEG_W-1:0] seg;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic run_val, fresh, last, rd_q, wr_q;

  wire bit_now = seg[0];
  wire split   = !fresh && (bit_now != run_val || cnt == CNT_MAX);

  assign rd_req   = rd_q;
  assign wr_req   = wr_q;
  assign word_out = {run_val, cnt};

  always_comb begin
    st_nx = st;
    case (st)
      ST_INIT:      st_nx = ST_FETCH;
      ST_FETCH:     if (src_ready) st_nx = ST_IN_STALL;
                    else if (stream_end && cnt != '0) st_nx = ST_EMIT;
      ST_IN_STALL:  st_nx = ST_LOAD;
      ST_LOAD:      st_nx = ST_COUNT;
      ST_COUNT:     st_nx = split ? ST_EMIT : ST_SHIFT;
      ST_SHIFT:     st_nx = (idx == IDX_LAST) ? ST_FETCH : ST_COUNT;
      ST_EMIT:      if (sink_ready) st_nx = ST_OUT_STALL;
      ST_OUT_STALL: st_nx = ST_CLEAR;
      ST_CLEAR:     st_nx = last ? ST_INIT : ST_COUNT;
      default:      st_nx = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_INIT;
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      seg <= '0;
      idx <= '0;
      cnt <= '0;
      run_val <= 1'b0;
      fresh <= 1'b1;
      last <= 1'b0;
    end else begin
      st <= st_nx;
      case (st)
        ST_INIT: begin
          cnt <= '0;
          seg <= '0;
          rd_q <= 1'b0;
          wr_q <= 1'b0;
          fresh <= 1'b1;
          last <= 1'b0;
        end
        ST_FETCH:
          if (src_ready) begin
            rd_q <= 1'b1;
            idx <= '0;
          end else begin
            last <= stream_end && cnt != '0;
          end
        ST_IN_STALL: rd_q <= 1'b0;
        ST_LOAD:     seg <= src_data;
        ST_COUNT:
          if (fresh) begin
            run_val <= bit_now;
            cnt <= cnt + 1'b1;
            fresh <= 1'b0;
          end else if (split) begin
            fresh <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        ST_SHIFT: begin
          seg <= seg >> 1;
          idx <= idx + 1'b1;
        end
        ST_EMIT:      if (sink_ready) wr_q <= 1'b1;
        ST_OUT_STALL: wr_q <= 1'b0;
        ST_CLEAR:     cnt <= '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/run_enc_checker.sv
module run_enc_checker #(
  parameter int CNT_W = 23
) (
  input logic           clk,
  input logic           rst,
  input logic           src_ready,
  input logic           sink_ready,
  input logic           rd_req,
  input logic           wr_req,
  input logic [CNT_W:0] word_out
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rd_req && !wr_req));

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (word_out[CNT_W-1:0] != '0));

  assert_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_rd_needs_ready_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> $past(src_ready));

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);

  assert_wr_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_req) |-> $past(sink_ready));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));
endmodule

bind bit_run_encoder run_enc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .src_ready(src_ready), .sink_ready(sink_ready),
  .rd_req(rd_req), .wr_req(wr_req), .word_out(word_out)
);

// File: tb/sim_bit_run_encoder.sv
module sim_bit_run_encoder;
  localparam int CLK_P = 10;
  localparam int CW = 5;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic src_ready, stream_end = 1'b0, sink_ready = 1'b1;
  logic [7:0] src_data = '0;
  logic rd_req, wr_req;
  logic [CW:0] word_out;

  logic [7:0] in_mem [0:63];
  int nbytes = 0, rp = 0;
  logic [CW:0] got [0:63];
  int got_n = 0, rd_cnt = 0, bad_wr = 0, bad_pulse = 0, bad_both = 0;
  logic wr_prev = 1'b0;
  int exp_val [0:63];
  int exp_len [0:63];
  int exp_n;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  bit_run_encoder #(.SEG_W(8), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .src_ready(src_ready), .src_data(src_data),
    .stream_end(stream_end), .sink_ready(sink_ready),
    .rd_req(rd_req), .wr_req(wr_req), .word_out(word_out)
  );

  always #(CLK_P/2) clk = ~clk;

  assign src_ready = rp < nbytes;

  always @(posedge clk) begin
    if (rst) begin
      rp <= 0; rd_cnt <= 0; got_n <= 0; wr_prev <= 1'b0;
    end else begin
      wr_prev <= wr_req;
      if (rd_req) begin
        rd_cnt <= rd_cnt + 1;
        if (rp < nbytes) begin
          src_data <= in_mem[rp];
          rp <= rp + 1;
        end
      end
      if (wr_req) begin
        got[got_n] <= word_out;
        got_n <= got_n + 1;
        if (!sink_ready) bad_wr <= bad_wr + 1;
      end
      if (wr_req && wr_prev) bad_pulse <= bad_pulse + 1;
      if (wr_req && rd_req) bad_both <= bad_both + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic build_expect();
    int cv = 0, cl = 0;
    bit have = 0;
    exp_n = 0;
    for (int i = 0; i < nbytes; i++)
      for (int b = 0; b < 8; b++) begin
        int bt = int'(in_mem[i][b]);
        if (!have) begin cv = bt; cl = 1; have = 1; end
        else if (bt == cv && cl < MAXC) cl++;
        else begin
          exp_val[exp_n] = cv; exp_len[exp_n] = cl; exp_n++;
          cv = bt; cl = 1;
        end
      end
    if (have) begin exp_val[exp_n] = cv; exp_len[exp_n] = cl; exp_n++; end
  endtask

  task automatic run_stream(input int nb, input int stall, input string tag);
    rst = 1'b1;
    nbytes = nb;
    sink_ready = 1'b1;
    stream_end = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    if (stall > 0) begin
      sink_ready = 1'b0;
      repeat (stall) @(negedge clk);
      sink_ready = 1'b1;
    end
    repeat (nb * 80 + 100) @(negedge clk);
    build_expect();
    chk(got_n == exp_n, {tag, " word count"}, got_n, exp_n);
    chk(rd_cnt == nb, "R5 one read pulse per segment", rd_cnt, nb);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(int'(got[k][CW]) == exp_val[k], {tag, " run value"}, int'(got[k][CW]), exp_val[k]);
      chk(int'(got[k][CW-1:0]) == exp_len[k], {tag, " run length"}, int'(got[k][CW-1:0]), exp_len[k]);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    nbytes = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_req == 1'b0, "R1 rd_req low in reset", int'(rd_req), 0);
    chk(wr_req == 1'b0, "R1 wr_req low in reset", int'(wr_req), 0);
    chk(got_n == 0, "R1 no word in reset", got_n, 0);
  endtask

  task automatic t_ones();
    in_mem[0] = 8'hFF; in_mem[1] = 8'hFF;
    run_stream(2, 0, "R4 span");
    chk(got[0] == {1'b1, 5'd16}, "R2 R4 single word 1/16", int'(got[0]), 48);
  endtask

  task automatic t_alt();
    in_mem[0] = 8'h55;
    run_stream(1, 0, "R3 alternating");
    chk(got[0] == {1'b1, 5'd1}, "R3 first word from bit0", int'(got[0]), 33);
    chk(got[1] == {1'b0, 5'd1}, "R3 second word", int'(got[1]), 1);
  endtask

  task automatic t_mixed();
    in_mem[0] = 8'h0F; in_mem[1] = 8'hF0;
    run_stream(2, 0, "R4 mixed");
    chk(got[1] == {1'b0, 5'd8}, "R4 zero run spans segments", int'(got[1]), 8);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 5; i++) in_mem[i] = 8'hFF;
    run_stream(5, 0, "R10 saturate");
    chk(got[0] == {1'b1, 5'd31}, "R10 full-length word", int'(got[0]), 63);
    chk(got[1] == {1'b1, 5'd9}, "R10 restarted run", int'(got[1]), 41);
  endtask

  task automatic t_empty();
    run_stream(0, 0, "R8 empty stream");
    chk(got_n == 0, "R8 zero pending writes nothing", got_n, 0);
  endtask

  task automatic t_tail();
    in_mem[0] = 8'h07;
    run_stream(1, 0, "R9 end held early");
    chk(got[1] == {1'b0, 5'd5}, "R8 final partial run flushed", int'(got[1]), 5);
    chk(got_n == 2, "R9 no early flush", got_n, 2);
  endtask

  task automatic t_backpressure();
    in_mem[0] = 8'h33; in_mem[1] = 8'hC3;
    run_stream(2, 300, "R7 stalled sink");
    chk(bad_wr == 0, "R6 wr_req only with sink_ready", bad_wr, 0);
  endtask

  initial begin
    t_reset();
    t_ones();
    t_alt();
    t_mixed();
    t_sat();
    t_empty();
    t_tail();
    t_backpressure();
    chk(bad_pulse == 0, "R6 wr_req single cycle", bad_pulse, 0);
    chk(bad_both == 0, "R11 rd and wr never together", bad_both, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule